// File: doc/BRIEF.md
# Calendar Time Keeper with Deferred Register Commit

This block keeps wall-clock time and calendar date as two packed words: one holds hour, minute and second, the other holds day, month, a six-bit year offset counted from 1970 (so the usable span runs to the end of 2033) and a leap-year flag. Each pulse on a one-hertz enable input moves the time on by one second. A carry ripples from seconds through minutes and hours into the day. From there it moves into the month and the year. February's length comes from the leap flag.

Software writes either word through a small memory-mapped port. A write does not take effect at once. The block holds the new value and raises a per-word busy flag in a control word. The value is loaded only after a fixed number of tick pulses, which stands in for a transfer into a slow clock domain. Software polls the flag before it trusts the new value. Until the load happens, the live word keeps counting from its old contents. Reads are combinational, so software must read both words twice and compare to catch a carry between the two reads.

Top module: `rtc_cal_regs`

## Requirements
- R1: After reset the time word reads 00:00:00, the date word reads day 1, month 1, year offset 0, leap 0, and the control word reads 0.
- R2: Word map by byte offset: control at 0x00 (bit 7 = date busy, bit 8 = time busy, bit 9 and all other bits read 0); date at 0x10 (day bits 4:0, month bits 11:8, year offset bits 21:16, leap bit 22); time at 0x14 (seconds bits 5:0, minutes bits 13:8, hours bits 20:16). Unused bits, and any other offset, read 0.
- R3: Each tick adds one second. Seconds 59 wrap to 0 and carry into minutes, minutes 59 wrap and carry into hours, and 23:59:59 becomes 00:00:00 and advances the day.
- R4: The day wraps to 1 and the month advances when the day equals the month's length: 30 for months 4, 6, 9 and 11, 31 for the other months except 2, and for month 2 either 29 (leap bit 1) or 28 (leap bit 0).
- R5: Rolling past the last day of month 12 sets month 1, adds one to the year offset (63 wraps to 0) and sets the leap bit to 1 exactly when the new offset modulo 4 equals 2.
- R6: A write to the time word sets control bit 8 from the next cycle. The live time keeps counting from its old value. On the COMMIT_TICKS-th tick after the write (default 2), that tick loads the written value with no increment and clears bit 8.
- R7: A write to the date word behaves the same way with control bit 7 and the date word. A date load on a tick overrides any day carry on that tick.
- R8: A write to a word whose busy bit is set is ignored: the value already pending is the one loaded.
- R9: Without a tick pulse neither word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| reg_addr | input | ADDR_W (8) | Byte offset of the accessed word |
| reg_wr | input | 1 | Write strobe for reg_addr |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |

## Verification
Counting is tried from states placed by a committed write. These states are a mid-minute count, a second-to-minute carry, a minute-to-hour carry, and a full midnight rollover into 30-day, 31-day and both February month ends. Each is followed by a single tick or a few ticks, so each month length and leap case shows up as a distinct next date. Year-end cases from offsets 29, 30 and 63 separate leap recomputation from the plain increment and show the wrap. Directed sequences check that the old value keeps counting while the busy flag is up and that the commit tick loads without incrementing. They also check that a second write during the pending window leaves no trace.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int unsigned WORD_W = 32;

    // byte offsets of the three words
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_DATE = 8'h10;
    localparam logic [7:0] OFS_TIME = 8'h14;

    // control word flag positions
    localparam int unsigned BIT_DATE_BUSY  = 7;
    localparam int unsigned BIT_TIME_BUSY  = 8;

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;
    localparam logic [3:0] MON_LAST  = 4'd12;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } hms_t;

    typedef struct packed {
        logic       leap;
        logic [5:0] year;
        logic [3:0] month;
        logic [4:0] day;
    } ymd_t;

    localparam hms_t HMS_RESET = '{hour: 5'd0, min: 6'd0, sec: 6'd0};
    localparam ymd_t YMD_RESET = '{leap: 1'b0, year: 6'd0, month: 4'd1, day: 5'd1};

    function automatic logic [WORD_W-1:0] hms_to_word(input hms_t t);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[5:0]   = t.sec;
        w[13:8]  = t.min;
        w[20:16] = t.hour;
        return w;
    endfunction

    function automatic hms_t word_to_hms(input logic [WORD_W-1:0] w);
        hms_t t;
        t.sec  = w[5:0];
        t.min  = w[13:8];
        t.hour = w[20:16];
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] ymd_to_word(input ymd_t d);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[4:0]   = d.day;
        w[11:8]  = d.month;
        w[21:16] = d.year;
        w[22]    = d.leap;
        return w;
    endfunction

    function automatic ymd_t word_to_ymd(input logic [WORD_W-1:0] w);
        ymd_t d;
        d.day   = w[4:0];
        d.month = w[11:8];
        d.year  = w[21:16];
        d.leap  = w[22];
        return d;
    endfunction

    // offset 0 is 1970; a year is leap when (1970 + y) % 4 == 0
    function automatic logic leap_of(input logic [5:0] y);
        return (y[1:0] == 2'd2);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        logic [4:0] n;
        case (m)
            4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
            4'd2:                    n = leap ? 5'd29 : 5'd28;
            default:                 n = 5'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_commit_slot.sv
// Holds one written word until DELAY tick pulses have passed, then
// emits a one-cycle commit alongside the held value.
module rtc_commit_slot #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DELAY = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             req,
    input  logic [WIDTH-1:0] req_data,
    output logic             busy,
    output logic             commit,
    output logic [WIDTH-1:0] held
);
    localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt;

    assign commit = busy && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            held <= '0;
        end else if (!busy) begin
            if (req) begin
                busy <= 1'b1;
                cnt  <= '0;
                held <= req_data;
            end
        end else if (tick) begin
            if (cnt == LAST) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_hms_counter.sv
module rtc_hms_counter
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  hms_t load_val,
    output hms_t cur,
    output logic day_carry
);
    logic at_midnight_edge;

    always_comb begin
        at_midnight_edge = (cur.sec >= SEC_LAST) && (cur.min >= MIN_LAST)
                           && (cur.hour >= HOUR_LAST);
        day_carry = tick && !load && at_midnight_edge;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= HMS_RESET;
        end else if (load) begin
            cur <= load_val;
        end else if (tick) begin
            if (cur.sec >= SEC_LAST) begin
                cur.sec <= '0;
                if (cur.min >= MIN_LAST) begin
                    cur.min <= '0;
                    if (cur.hour >= HOUR_LAST) begin
                        cur.hour <= '0;
                    end else begin
                        cur.hour <= cur.hour + 1'b1;
                    end
                end else begin
                    cur.min <= cur.min + 1'b1;
                end
            end else begin
                cur.sec <= cur.sec + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_ymd_counter.sv
module rtc_ymd_counter
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic load,
    input  ymd_t load_val,
    output ymd_t cur
);
    logic       month_end;
    logic       year_end;
    logic [5:0] next_year;

    always_comb begin
        month_end = (cur.day >= month_len(cur.month, cur.leap));
        year_end  = (cur.month >= MON_LAST);
        next_year = cur.year + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= YMD_RESET;
        end else if (load) begin
            cur <= load_val;
        end else if (adv) begin
            if (month_end) begin
                cur.day <= 5'd1;
                if (year_end) begin
                    cur.month <= 4'd1;
                    cur.year  <= next_year;
                    cur.leap  <= leap_of(next_year);
                end else begin
                    cur.month <= cur.month + 1'b1;
                end
            end else begin
                cur.day <= cur.day + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
    import rtc_cal_pkg::*;
#(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned COMMIT_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int unsigned HMS_W = $bits(hms_t);
    localparam int unsigned YMD_W = $bits(ymd_t);

    logic sel_ctrl, sel_date, sel_time;
    logic time_busy, date_busy;
    logic time_commit, date_commit;
    logic [HMS_W-1:0] time_held;
    logic [YMD_W-1:0] date_held;
    hms_t hms_cur;
    ymd_t ymd_cur;
    logic day_carry;
    hms_t hms_wr;
    ymd_t ymd_wr;

    assign sel_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
    assign sel_date = (reg_addr == ADDR_W'(OFS_DATE));
    assign sel_time = (reg_addr == ADDR_W'(OFS_TIME));
    assign hms_wr   = word_to_hms(reg_wdata);
    assign ymd_wr   = word_to_ymd(reg_wdata);

    rtc_commit_slot #(.WIDTH(HMS_W), .DELAY(COMMIT_TICKS)) time_slot_i (
        .clk(clk), .rst(rst), .tick(tick_1hz),
        .req(reg_wr && sel_time), .req_data(hms_wr),
        .busy(time_busy), .commit(time_commit), .held(time_held)
    );

    rtc_commit_slot #(.WIDTH(YMD_W), .DELAY(COMMIT_TICKS)) date_slot_i (
        .clk(clk), .rst(rst), .tick(tick_1hz),
        .req(reg_wr && sel_date), .req_data(ymd_wr),
        .busy(date_busy), .commit(date_commit), .held(date_held)
    );

    rtc_hms_counter hms_i (
        .clk(clk), .rst(rst), .tick(tick_1hz),
        .load(time_commit), .load_val(hms_t'(time_held)),
        .cur(hms_cur), .day_carry(day_carry)
    );

    rtc_ymd_counter ymd_i (
        .clk(clk), .rst(rst), .adv(day_carry),
        .load(date_commit), .load_val(ymd_t'(date_held)),
        .cur(ymd_cur)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[BIT_DATE_BUSY] = date_busy;
            reg_rdata[BIT_TIME_BUSY] = time_busy;
        end else if (sel_date) begin
            reg_rdata = ymd_to_word(ymd_cur);
        end else if (sel_time) begin
            reg_rdata = hms_to_word(hms_cur);
        end
    end
endmodule

// File: rtl/rtc_cal_regs_chk.sv
module rtc_cal_regs_chk
    import rtc_cal_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tick,
    input logic time_busy,
    input logic date_busy,
    input hms_t hms,
    input ymd_t ymd
);
    // R9
    time_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(hms));

    // R9
    date_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(ymd));

    // R3
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !time_busy && hms.sec < SEC_LAST) |=> hms.sec == $past(hms.sec) + 6'd1);

    // R6
    time_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (time_busy && !tick) |=> time_busy);

    // R7
    date_busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (date_busy && !tick) |=> date_busy);

    // R6
    time_clear_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(time_busy) |-> $past(tick));
endmodule

bind rtc_cal_regs rtc_cal_regs_chk chk_i (
    .clk(clk), .rst(rst), .tick(tick_1hz),
    .time_busy(time_busy), .date_busy(date_busy),
    .hms(hms_cur), .ymd(ymd_cur)
);

// File: tb/rtc_cal_regs_tb_top.sv
module rtc_cal_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rtc_cal_regs dut_i (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz),
        .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] mk_t(input int h, input int m, input int s);
        return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] mk_d(input int y, input int mo, input int d, input int lp);
        return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    typedef struct packed {
        logic [31:0] t0;
        logic [31:0] d0;
        logic [7:0]  n;
        logic [31:0] te;
        logic [31:0] de;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t [0:NV-1] VEC = '{
        '{mk_t(10,20,30), mk_d(30,3,15,1), 8'd5, mk_t(10,20,35), mk_d(30,3,15,1)}, // R3
        '{mk_t(10,20,58), mk_d(30,3,15,1), 8'd3, mk_t(10,21,1),  mk_d(30,3,15,1)}, // R3
        '{mk_t(10,59,59), mk_d(30,3,15,1), 8'd1, mk_t(11,0,0),   mk_d(30,3,15,1)}, // R3
        '{mk_t(23,59,59), mk_d(5,6,30,0),  8'd1, mk_t(0,0,0),    mk_d(5,7,1,0)},   // R4
        '{mk_t(23,59,59), mk_d(30,2,28,1), 8'd1, mk_t(0,0,0),    mk_d(30,2,29,1)}, // R4
        '{mk_t(23,59,59), mk_d(31,2,28,0), 8'd1, mk_t(0,0,0),    mk_d(31,3,1,0)},  // R4
        '{mk_t(23,59,59), mk_d(30,2,29,1), 8'd1, mk_t(0,0,0),    mk_d(30,3,1,1)},  // R4
        '{mk_t(23,59,59), mk_d(1,4,30,0),  8'd1, mk_t(0,0,0),    mk_d(1,5,1,0)},   // R4
        '{mk_t(23,59,59), mk_d(1,1,31,0),  8'd1, mk_t(0,0,0),    mk_d(1,2,1,0)},   // R4
        '{mk_t(23,59,59), mk_d(29,12,31,0),8'd1, mk_t(0,0,0),    mk_d(30,1,1,1)},  // R5
        '{mk_t(23,59,59), mk_d(30,12,31,1),8'd1, mk_t(0,0,0),    mk_d(31,1,1,0)},  // R5
        '{mk_t(23,59,59), mk_d(63,12,31,0),8'd1, mk_t(0,0,0),    mk_d(0,1,1,0)}    // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h14, v); check("R1 time", v, mk_t(0,0,0));
        rd(8'h10, v); check("R1 date", v, mk_d(0,1,1,0));
        rd(8'h00, v); check("R1 ctrl", v, 32'h0);

        // R6 time write: busy, old value keeps counting
        wr(8'h14, mk_t(1,2,3));
        rd(8'h00, v); check("R6 ctrl time busy", v, 32'h100);
        rd(8'h14, v); check("R6 old time held", v, mk_t(0,0,0));
        pulse();
        rd(8'h14, v); check("R6 old time counts", v, mk_t(0,0,1));
        rd(8'h00, v); check("R6 still busy", v, 32'h100);
        // R8 write while busy must vanish
        wr(8'h14, mk_t(5,5,5));
        rd(8'h00, v); check("R8 ctrl unchanged", v, 32'h100);
        pulse();
        rd(8'h14, v); check("R6 commit no increment", v, mk_t(1,2,3));
        rd(8'h00, v); check("R6 busy cleared", v, 32'h0);
        pulse();
        rd(8'h14, v); check("R8 ignored write absent", v, mk_t(1,2,4));

        // R7 date write
        wr(8'h10, mk_d(2,3,4,0) | 32'hFF80_E0E0);
        rd(8'h00, v); check("R7 ctrl date busy", v, 32'h80);
        rd(8'h10, v); check("R7 old date held", v, mk_d(0,1,1,0));
        pulse();
        pulse();
        rd(8'h10, v); check("R7 date committed", v, mk_d(2,3,4,0));
        rd(8'h00, v); check("R7 busy cleared", v, 32'h0);

        // R9 no tick, no change
        repeat (10) @(negedge clk);
        rd(8'h14, v); check("R9 time idle", v, mk_t(1,2,6));
        rd(8'h10, v); check("R9 date idle", v, mk_d(2,3,4,0));

        // R2 unused offset and bits
        rd(8'h04, v); check("R2 unmapped", v, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R2 bit9 zero", v & 32'h200, 32'h0);
        pulse();
        pulse();
        rd(8'h14, v); check("R2 time fields", v, mk_t(31,63,63));

        // vector table: place state, commit, tick, compare (R3 R4 R5)
        for (int i = 0; i < NV; i++) begin
            wr(8'h14, VEC[i].t0);
            wr(8'h10, VEC[i].d0);
            pulse();
            pulse();
            for (int k = 0; k < int'(VEC[i].n); k++) pulse();
            rd(8'h14, v); check($sformatf("R3 vec%0d time", i), v, VEC[i].te);
            rd(8'h10, v); check($sformatf("R4/R5 vec%0d date", i), v, VEC[i].de);
        end

        finish_up();
    end
endmodule